// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block collects up to eight interrupt sources into one status word that a host reads. Each status bit latches when its source fires and stays set until the host reads the word, so a short pulse is not lost between two reads. A companion mask input enables or disables each source. A disabled bit never latches and always reads back as zero. A per-source mode input picks how the source is seen. In edge mode a rising edge of the source is the event. In level mode the event is the source being high, and a read cannot clear the bit while the source is still high.

A read is a one-cycle strobe. The data port always shows the current masked status, so the value the host captures during the strobe is the value before clearing. The interrupt output is high whenever any visible status bit is set. The host bus and the sources themselves are outside the block. The sources are plain synchronous inputs.

Top module: `sirq_status_reg`

## Requirements
- R1: While reset is active and in the first cycle after it, all status bits are 0 and the interrupt output is low.
- R2: With its mask bit at 1 and its mode bit at 0 (edge), a source that goes from 0 to 1 sets its status bit one clock later. The bit stays 1 after the source returns to 0, until a read strobe.
- R3: During a read strobe the data port shows the status before clearing. After the strobe, every edge-mode bit reads 0 unless a new rising edge occurred in the strobe cycle. This holds even when the source is still held high.
- R4: With its mode bit at 1 (level), a bit is set one clock after any cycle in which its source is high. A read strobe taken while the source is high leaves the bit at 1. A read taken after the source has dropped clears it.
- R5: If a source event (edge or level) and a read strobe occur in the same cycle, the bit reads 1 after the strobe, so no event is lost.
- R6: A bit whose mask is 0 reads 0 at once and does not latch events. Setting the mask to 1 later does not reveal events that occurred while the bit was masked.
- R7: The interrupt output is 1 exactly when at least one bit on the data port is 1. Clearing the mask of the only set bit drops the interrupt output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Interrupt source inputs, one per bit |
| mask_i | input | NUM_SRC | Per-source enable, 1 = enabled |
| mode_i | input | NUM_SRC | Per-source mode, 0 = edge, 1 = level |
| rd_i | input | 1 | Single-cycle read strobe; clears status at the next edge |
| rd_data_o | output | NUM_SRC | Masked status word (value before clearing) |
| irq_o | output | 1 | High when any bit of rd_data_o is 1 |

## Verification
Several directed patterns are applied. A one-cycle pulse separates sticky latching from simple pass-through. A source held high across a read separates edge-mode clearing from level-mode retention. A pulse that lands on the read strobe shows whether the event or the clear takes priority. Pulses on masked bits, followed by unmasking, show whether masked events leak into the register. A long pseudo-random run with mixed masks, modes and read strobes then covers the interactions between bits. Every cycle is compared against a behavioural model that keeps one integer per bit.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int SIRQ_MAX_SRC = 8;

    typedef enum logic {
        SIRQ_EDGE  = 1'b0,
        SIRQ_LEVEL = 1'b1
    } sirq_mode_e;

endpackage

// File: rtl/sirq_event_gen.sv
module sirq_event_gen
    import sirq_pkg::*;
(
    input  logic src_i,
    input  logic src_prev_i,
    input  logic mode_i,
    output logic event_o
);
    // Edge mode fires on 0->1; level mode fires whenever the source is high.
    always_comb begin
        if (sirq_mode_e'(mode_i) == SIRQ_LEVEL) begin
            event_o = src_i;
        end else begin
            event_o = src_i & ~src_prev_i;
        end
    end
endmodule

// File: rtl/sirq_bit_next.sv
module sirq_bit_next (
    input  logic enable_i,
    input  logic event_i,
    input  logic held_i,
    input  logic rd_i,
    output logic next_o
);
    // An event wins over a clear; a disabled bit never holds state.
    always_comb begin
        if (!enable_i) begin
            next_o = 1'b0;
        end else if (event_i) begin
            next_o = 1'b1;
        end else if (rd_i) begin
            next_o = 1'b0;
        end else begin
            next_o = held_i;
        end
    end
endmodule

// File: rtl/sirq_status_reg.sv
module sirq_status_reg
    import sirq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] mode_i,
    input  logic               rd_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               irq_o
);
    localparam int W = (NUM_SRC < SIRQ_MAX_SRC) ? NUM_SRC : SIRQ_MAX_SRC;

    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] src_prev;
    } state_t;

    state_t       state_d, state_q;
    logic [W-1:0] event_w;
    logic [W-1:0] next_w;

    for (genvar i = 0; i < W; i++) begin : g_bit
        sirq_event_gen u_event (
            .src_i      (src_i[i]),
            .src_prev_i (state_q.src_prev[i]),
            .mode_i     (mode_i[i]),
            .event_o    (event_w[i])
        );

        sirq_bit_next u_next (
            .enable_i (mask_i[i]),
            .event_i  (event_w[i]),
            .held_i   (state_q.status[i]),
            .rd_i     (rd_i),
            .next_o   (next_w[i])
        );
    end

    always_comb begin
        state_d          = state_q;
        state_d.status   = next_w;
        state_d.src_prev = src_i[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // A bit masked off right now reads zero without waiting a clock.
    always_comb begin
        rd_data_o        = '0;
        rd_data_o[W-1:0] = state_q.status & mask_i[W-1:0];
        irq_o            = |rd_data_o;
    end
endmodule

// File: rtl/sirq_status_chk.sv
module sirq_status_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [NUM_SRC-1:0] mask_i,
    input logic [NUM_SRC-1:0] mode_i,
    input logic               rd_i,
    input logic [NUM_SRC-1:0] rd_data_o,
    input logic               irq_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data_o == '0) && !irq_o);

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (($past(rd_data_o) & mask_i & ~rd_data_o) == '0));

    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((rd_data_o & ~$past(src_i)) == '0));

    // R4
    level_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (($past(mode_i & src_i & mask_i) & mask_i & ~rd_data_o) == '0));

    // R6
    masked_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data_o & ~$past(mask_i)) == '0));

    // R7
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (rd_data_o != '0));
endmodule

bind sirq_status_reg sirq_status_chk #(.NUM_SRC(NUM_SRC)) u_sirq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .mask_i    (mask_i),
    .mode_i    (mode_i),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o)
);

// File: tb/tb_sirq_status_reg.sv
module tb_sirq_status_reg;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_i = '0;
    logic [N-1:0] mask_i = '0;
    logic [N-1:0] mode_i = '0;
    logic         rd_i = 1'b0;
    logic [N-1:0] rd_data_o;
    logic         irq_o;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    int    st   [N];
    int    prv  [N];
    int    lfsr = 32'h1d2c3b4a;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    sirq_status_reg #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .mask_i(mask_i),
        .mode_i(mode_i), .rd_i(rd_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic logic [N-1:0] model_word();
        logic [N-1:0] w = '0;
        for (int i = 0; i < N; i++) w[i] = (st[i] != 0) && mask_i[i];
        return w;
    endfunction

    task automatic compare();
        logic [N-1:0] ew = model_word();
        n_vec++;
        if (rd_data_o !== ew || irq_o !== (ew != '0)) begin
            n_bad++;
            $display("FAIL %s: data=%h irq=%b expected data=%h irq=%b",
                     cur_req, rd_data_o, irq_o, ew, (ew != '0));
        end
    endtask

    task automatic direct(string req, logic [N-1:0] exp_w);
        n_vec++;
        if (rd_data_o !== exp_w) begin
            n_bad++;
            $display("FAIL %s: data=%h expected %h", req, rd_data_o, exp_w);
        end
    endtask

    // One clock: compare, drive new inputs, advance model on the edge.
    task automatic step(logic [N-1:0] s, logic [N-1:0] m, logic [N-1:0] md, logic r);
        compare();
        src_i = s; mask_i = m; mode_i = md; rd_i = r;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            int ev;
            if (!rst_n) begin
                st[i] = 0; prv[i] = 0;
            end else begin
                ev = md[i] ? int'(s[i]) : int'(s[i] && prv[i] == 0);
                if (!m[i]) st[i] = 0;
                else if (ev != 0) st[i] = 1;
                else if (r) st[i] = 0;
                prv[i] = s[i];
            end
        end
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin st[i] = 0; prv[i] = 0; end
        @(negedge clk);
        // R1 reset state, sources active during reset
        step(8'hff, 8'hff, 8'h00, 1'b0);
        step(8'hff, 8'hff, 8'hff, 1'b0);
        direct("R1", 8'h00);
        rst_n = 1'b1;
        step(8'h00, 8'hff, 8'h00, 1'b0);
        direct("R1", 8'h00);

        cur_req = "R2";
        step(8'h01, 8'hff, 8'h00, 1'b0);
        step(8'h00, 8'hff, 8'h00, 1'b0);
        for (int k = 0; k < 4; k++) step(8'h00, 8'hff, 8'h00, 1'b0);
        direct("R2", 8'h01);

        cur_req = "R3";
        step(8'h02, 8'hff, 8'h00, 1'b0);
        step(8'h02, 8'hff, 8'h00, 1'b0);
        direct("R3", 8'h03);
        step(8'h02, 8'hff, 8'h00, 1'b1);
        direct("R3", 8'h00);
        step(8'h00, 8'hff, 8'h00, 1'b0);

        cur_req = "R4";
        step(8'h04, 8'hff, 8'h04, 1'b0);
        step(8'h04, 8'hff, 8'h04, 1'b1);
        direct("R4", 8'h04);
        step(8'h00, 8'hff, 8'h04, 1'b0);
        step(8'h00, 8'hff, 8'h04, 1'b1);
        direct("R4", 8'h00);

        cur_req = "R5";
        step(8'h08, 8'hff, 8'h00, 1'b1);
        direct("R5", 8'h08);
        step(8'h00, 8'hff, 8'h00, 1'b1);
        direct("R5", 8'h00);

        cur_req = "R6";
        step(8'h10, 8'hef, 8'h00, 1'b0);
        step(8'h00, 8'hef, 8'h00, 1'b0);
        step(8'h00, 8'hff, 8'h00, 1'b0);
        direct("R6", 8'h00);

        cur_req = "R7";
        step(8'h20, 8'hff, 8'h00, 1'b0);
        step(8'h00, 8'hff, 8'h00, 1'b0);
        mask_i = 8'hdf;
        #0.5;
        n_vec++;
        if (irq_o !== 1'b0 || rd_data_o !== 8'h00) begin
            n_bad++;
            $display("FAIL R7: irq=%b data=%h expected irq=0 data=00", irq_o, rd_data_o);
        end
        step(8'h00, 8'hff, 8'h00, 1'b1);

        cur_req = "R2/R3/R4/R5/R6/R7 random";
        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] s, m, md;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            s  = lfsr[7:0] & lfsr[15:8];
            m  = lfsr[23:16] | 8'h0f;
            md = 8'hc3;
            step(s, m, md, lfsr[26] & lfsr[27]);
        end
        compare();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule